// File: doc/BRIEF.md
# Multi-Lane Bonding Deskew

This block lines up symbol streams that arrive on several receive lanes with different path delays. All lanes share one clock and present one symbol each per accepted input beat. Every symbol is an 8-bit byte plus a control flag. Each lane writes into its own small circular buffer, and every lane has its own read pointer into that buffer.

A transmitter marks alignment by sending a reserved control symbol, the bonding character, on every lane in the same transmit slot. One lane is fixed as the master. When the master's copy is written, the block looks for each slave's copy. The slave's copy may have arrived up to a set window of symbols earlier or may arrive up to that window later. Once every lane has its copy, each lane's read pointer moves to the buffer slot holding that lane's own copy. From then on, one output word carries the symbols of the same transmit slot on all lanes, and a `bonded` flag goes high.

Both edges of the block use valid/ready. On the input side a beat is taken for all lanes at once when `in_valid` and `in_ready` are both high. `in_ready` falls only while some lane's buffer is full. On the output side a word is consumed when `out_valid` and `out_ready` are both high. While `out_ready` is low, a presented word stays put. The one exception is the beat on which a new bonding event starts, because the read pointers are about to jump; on that beat `out_valid` may be withdrawn. The bonding character itself is delivered with its control flag set, so logic further down can discard it.

Top module: `lane_bond_deskew`

## Requirements
- R1: After reset, `bonded`, `bond_err` and `out_valid` are 0 and `in_ready` is 1.
- R2: `in_ready` is 0 exactly while some lane holds DEPTH unread symbols. While bonding has never moved a pointer, all lanes hold the same count: accepted beats minus consumed words.
- R3: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` high with unchanged `out_data`/`out_ctrl`, unless a bonding event starts on that beat.
- R4: Lane l carries its byte on `in_data[8l+7:8l]` and its control flag on `in_ctrl[l]`. A symbol is the bonding character only when the flag is 1 and the byte equals `bond_char`. With the flag at 0 the same byte is payload, passes through unchanged and starts nothing.
- R5: Only the master lane (MASTER, default lane 0) starts bonding. Bonding characters on slave lanes alone leave `bonded` and `bond_err` at 0.
- R6: A slave bonding character accepted up to WIN beats before or after the master's counts. After bonding, each output word holds, on every lane, the symbol sent in the same transmit slot.
- R7: The first word consumed after `bonded` rises is the bonding character on every lane, with its control flag set.
- R8: Count from the clock edge that accepts the last outstanding bonding character. The read pointers move on the next edge, and `bonded` rises on the edge after that.
- R9: If a slave's bonding character falls outside the window, `bond_err` goes to 1 and `bonded` stays 0. The read pointers are left as they were, so lockstep reading continues.
- R10: `bonded` stays 1 until reset or until the next master bonding character is accepted, which clears it.
- R11: Before any bonding, lanes are read in lockstep: the k-th output word of each lane is that lane's k-th accepted symbol. From master detection until `bonded` rises, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bond_char | input | 8 | Byte value reserved as the bonding character |
| in_valid | input | 1 | A symbol for every lane is present |
| in_ready | output | 1 | All lane buffers can take a symbol |
| in_data | input | 8*LANES | Lane bytes, lane l at bits 8l+7:8l |
| in_ctrl | input | LANES | Control-symbol flag per lane |
| out_valid | output | 1 | An output word is presented |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 8*LANES | Output bytes, lane l at bits 8l+7:8l |
| out_ctrl | output | LANES | Control flag of each output byte |
| bonded | output | 1 | Lanes are aligned |
| bond_err | output | 1 | Last bonding attempt missed its window |

## Verification
The assertions assume a few things about the inputs. `bond_char` stays constant while traffic flows. No lane repeats the bonding character within 2*WIN+2 beats of a bonding event. The worst spread between the earliest and latest lane stays small enough that the span from any bonding character to the write pointer fits in the buffer. The stimulus builds each lane as a delayed copy of one transmit sequence, with skews between -(WIN+1) and WIN+1 beats. It fills the lead-in with a non-bonding idle control byte and places at most two bonding slots far apart, so every run stays inside those limits. The stimulus also steps downstream readiness through several fixed patterns so that the hold rule and the full-buffer stall are both exercised.

// File: rtl/bond_pkg.sv
package bond_pkg;
  localparam int SYM_W = 8;

  typedef struct packed {
    logic             ctl;
    logic [SYM_W-1:0] dat;
  } sym_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_ALIGN  = 2'd2,
    ST_DONE   = 2'd3
  } bst_t;
endpackage

// File: rtl/bond_lane.sv
module bond_lane
  import bond_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIN   = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int AGW  = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] bond_char,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  sym_t             wr_sym,
  input  logic             rd_en,
  input  logic             align_en,
  input  logic [AW-1:0]    wptr_nx,
  input  logic             hold_pos,
  output logic             char_hit,
  output logic             recent,
  output sym_t             rd_sym,
  output logic             nonempty,
  output logic             has_room
);
  sym_t            mem [DEPTH];
  logic [AW-1:0]   rptr;
  logic [AW:0]     cnt;
  logic [AW-1:0]   pos;
  logic [AGW-1:0]  age;
  logic            marked;

  assign char_hit = wr_en && wr_sym.ctl && (wr_sym.dat == bond_char);
  assign recent   = marked && (age < AGW'(WIN));
  assign rd_sym   = mem[rptr];
  assign nonempty = (cnt != '0);
  assign has_room = (cnt < (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_sym;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      cnt    <= '0;
      pos    <= '0;
      age    <= '0;
      marked <= 1'b0;
    end else begin
      if (align_en) begin
        rptr <= pos;
        cnt  <= {1'b0, wptr_nx - pos};
      end else begin
        if (rd_en) rptr <= rptr + 1'b1;
        cnt <= cnt + (AW+1)'(wr_en) - (AW+1)'(rd_en);
      end
      if (char_hit && !hold_pos) pos <= wr_addr;
      if (char_hit) begin
        age    <= '0;
        marked <= 1'b1;
      end else if (wr_en && age != AGW'(WIN)) begin
        age <= age + 1'b1;
      end
    end
  end

  // R2: occupancy never passes the buffer depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  // R2: a full lane accepts no write
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (AW+1)'(DEPTH)) |-> !wr_en);
endmodule

// File: rtl/bond_ctrl.sv
module bond_ctrl
  import bond_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int MASTER = 0,
  parameter int WIN    = 5,
  localparam int CW    = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LANES-1:0] hit,
  input  logic [LANES-1:0] recent,
  output logic             align_en,
  output logic [LANES-1:0] hold,
  output logic             rd_allow,
  output logic             bond_start,
  output logic             bonded,
  output logic             bond_err
);
  bst_t             st;
  logic [LANES-1:0] found, found_nx;
  logic [CW-1:0]    win;

  assign bond_start = (st == ST_IDLE) && fire && hit[MASTER];
  assign align_en   = (st == ST_ALIGN);
  assign rd_allow   = (st == ST_IDLE);
  assign hold       = (st == ST_SEARCH || st == ST_ALIGN) ? found : '0;

  always_comb begin
    found_nx = found;
    if (st == ST_IDLE) begin
      found_nx         = hit | recent;
      found_nx[MASTER] = 1'b1;
    end else if (st == ST_SEARCH && fire) begin
      found_nx = found | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      found    <= '0;
      win      <= '0;
      bonded   <= 1'b0;
      bond_err <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (bond_start) begin
          found    <= found_nx;
          bonded   <= 1'b0;
          bond_err <= 1'b0;
          win      <= '0;
          st       <= (&found_nx) ? ST_ALIGN : ST_SEARCH;
        end
        ST_SEARCH: if (fire) begin
          found <= found_nx;
          if (&found_nx) begin
            st <= ST_ALIGN;
          end else if (win == CW'(WIN - 1)) begin
            bond_err <= 1'b1;
            found    <= '0;
            st       <= ST_IDLE;
          end else begin
            win <= win + 1'b1;
          end
        end
        ST_ALIGN: st <= ST_DONE;
        ST_DONE: begin
          bonded <= 1'b1;
          found  <= '0;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: leaving idle needs a master bonding character
  a_r5_master_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !(fire && hit[MASTER])) |=> (st == ST_IDLE));
  // R8: bonded rises one cycle after the pointer move
  a_r8_bond_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bonded) |-> ($past(st, 2) == ST_ALIGN));
  // R9: an error never coexists with the bonded state
  a_r9_err_unbonded: assert property (@(posedge clk) disable iff (!rst_n)
    bond_err |-> !bonded);
  // R10: bonded holds until a new master event
  a_r10_bond_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bonded && !(fire && hit[MASTER])) |=> bonded);
endmodule

// File: rtl/lane_bond_deskew.sv
module lane_bond_deskew
  import bond_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 16,
  parameter int WIN    = 5,
  parameter int MASTER = 0,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SYM_W-1:0]       bond_char,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SYM_W*LANES-1:0] in_data,
  input  logic [LANES-1:0]       in_ctrl,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [SYM_W*LANES-1:0] out_data,
  output logic [LANES-1:0]       out_ctrl,
  output logic                   bonded,
  output logic                   bond_err
);
  logic [AW-1:0]    wptr, wptr_nx;
  logic             fire, rd_en, align_en, rd_allow, bond_start;
  logic [LANES-1:0] hit, recent, hold, nonempty, room;

  assign fire      = in_valid && in_ready;
  assign in_ready  = &room;
  assign out_valid = rd_allow && (&nonempty);
  assign rd_en     = out_valid && out_ready;
  assign wptr_nx   = wptr + AW'(fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr <= '0;
    else        wptr <= wptr_nx;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sym_t wsym, rsym;
    assign wsym.ctl = in_ctrl[l];
    assign wsym.dat = in_data[l*SYM_W +: SYM_W];
    assign out_ctrl[l] = rsym.ctl;
    assign out_data[l*SYM_W +: SYM_W] = rsym.dat;

    bond_lane #(.DEPTH(DEPTH), .WIN(WIN)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .bond_char(bond_char),
      .wr_en    (fire),
      .wr_addr  (wptr),
      .wr_sym   (wsym),
      .rd_en    (rd_en),
      .align_en (align_en),
      .wptr_nx  (wptr_nx),
      .hold_pos (hold[l]),
      .char_hit (hit[l]),
      .recent   (recent[l]),
      .rd_sym   (rsym),
      .nonempty (nonempty[l]),
      .has_room (room[l])
    );
  end

  bond_ctrl #(.LANES(LANES), .MASTER(MASTER), .WIN(WIN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .hit       (hit),
    .recent    (recent),
    .align_en  (align_en),
    .hold      (hold),
    .rd_allow  (rd_allow),
    .bond_start(bond_start),
    .bonded    (bonded),
    .bond_err  (bond_err)
  );

  // R3: a stalled word stays presented and unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !bond_start) |=>
      (out_valid && $stable(out_data) && $stable(out_ctrl)));
  // R4: bonding only starts on a flagged master symbol matching the char
  a_r4_start_char: assert property (@(posedge clk) disable iff (!rst_n)
    bond_start |-> (in_ctrl[MASTER] && in_data[MASTER*SYM_W +: SYM_W] == bond_char));
endmodule

// File: tb/sim_lane_bond_deskew.sv
`timescale 1ns/1ps
module sim_lane_bond_deskew;
  localparam int LANES = 4;
  localparam int DEPTH = 16;
  localparam int WIN   = 5;
  localparam int MASTER = 0;
  localparam logic [7:0] IDLE_B = 8'h1C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bond_char = 8'hBC;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [8*LANES-1:0] in_data = '0, out_data;
  logic [LANES-1:0] in_ctrl = '0, out_ctrl;
  logic bonded, bond_err;

  always #2.5 clk = ~clk;

  lane_bond_deskew #(.LANES(LANES), .DEPTH(DEPTH), .WIN(WIN), .MASTER(MASTER)) u0 (
    .clk(clk), .rst_n(rst_n), .bond_char(bond_char),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ctrl(out_ctrl),
    .bonded(bonded), .bond_err(bond_err));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int cur_b1, cur_b2, cur_mode;
  logic [7:0] cur_bc;
  int dly [LANES];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {ctl, byte} sent in transmit slot k on lane l
  function automatic logic [8:0] tx(input int l, input int k);
    if (k < 0) return {1'b1, IDLE_B};
    if (k == cur_b1 || k == cur_b2) begin
      if (cur_mode == 2) return {1'b0, cur_bc};
      if (cur_mode == 1 && l == MASTER) return {1'b0, 8'(k * 13 + l * 29 + 5)};
      return {1'b1, cur_bc};
    end
    return {1'b0, 8'(k * 13 + l * 29 + 5)};
  endfunction

  function automatic bit rdy_pat(input int p, input int cyc);
    case (p)
      1: return (cyc % 3) != 2;
      2: return cyc >= 40;
      default: return 1'b1;
    endcase
  endfunction

  task automatic trial(input int s1, input int s2, input int s3, input int b1,
                       input int b2, input int mode, input int pat, input logic [7:0] bc);
    int nsym, c, w, acc, rises, falls, slot, fire_last, clast, mx;
    bit ok_exp, nobond, bprev;
    int sk [LANES];
    sk[0] = 0; sk[1] = s1; sk[2] = s2; sk[3] = s3;
    cur_b1 = b1; cur_b2 = b2; cur_mode = mode; cur_bc = bc;
    nsym = 70;
    ok_exp = (mode == 0) && (b1 < nsym);
    for (int l = 0; l < LANES; l++) begin
      dly[l] = WIN + 1 + sk[l];
      if (sk[l] > WIN || sk[l] < -WIN) ok_exp = 1'b0;
    end
    nobond = (mode != 0) || (b1 >= nsym);
    mx = 0;
    for (int l = 0; l < LANES; l++) if (dly[l] > mx) mx = dly[l];
    clast = b1 + mx;

    in_valid = 1'b0; out_ready = 1'b0; bond_char = bc;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state after reset
    chk(!bonded && !bond_err, "R1 flags", {bonded, bond_err}, 0);
    chk(!out_valid && in_ready, "R1 handshake", {out_valid, in_ready}, 1);

    c = 0; w = 0; acc = 0; rises = 0; falls = 0; slot = 0; fire_last = -1; bprev = 1'b0;
    for (int cyc = 0; cyc < nsym + 60; cyc++) begin
      @(negedge clk);
      if (bonded && !bprev) begin
        rises++;
        slot = (rises == 1) ? b1 : b2;
      end
      if (!bonded && bprev) falls++;
      bprev = bonded;
      if (ok_exp && fire_last >= 0) begin
        if (cyc == fire_last + 2) chk(!bonded, "R8 not yet bonded", bonded, 0);
        if (cyc == fire_last + 3) chk(bonded, "R8 bonded rises", bonded, 1);
      end
      if (nobond) chk(in_ready == ((acc - w) < DEPTH), "R2 ready vs fill", in_ready, (acc - w) < DEPTH);
      out_ready = rdy_pat(pat, cyc);
      if (out_valid && out_ready) begin
        for (int l = 0; l < LANES; l++) begin
          logic [8:0] got, exp;
          got = {out_ctrl[l], out_data[l*8 +: 8]};
          if (bonded) begin
            exp = tx(l, slot);
            if (slot == b1 || slot == b2)
              chk(got == exp && got[8], "R7 bonding char first", got, exp);
            else
              chk(got == exp, "R6 aligned slot", got, exp);
          end else if (rises == 0) begin
            exp = tx(l, w - dly[l]);
            chk(got == exp, mode == 2 ? "R4 flagless byte is payload" : "R11 lockstep", got, exp);
          end
        end
        if (bonded) slot++;
        else if (rises == 0) w++;
      end
      if (c < nsym) begin
        in_valid = 1'b1;
        for (int l = 0; l < LANES; l++) begin
          logic [8:0] s;
          s = tx(l, c - dly[l]);
          in_ctrl[l] = s[8];
          in_data[l*8 +: 8] = s[7:0];
        end
        if (in_ready) begin
          if (c == clast) fire_last = cyc;
          c++;
          acc++;
        end
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(bonded == ok_exp, mode == 1 ? "R5 slave chars alone" : "R6 bonded result", bonded, ok_exp);
    chk(bond_err == (mode == 0 && b1 < nsym && !ok_exp), "R9 error flag", bond_err,
        (mode == 0 && b1 < nsym && !ok_exp));
    if (b2 >= 0) chk(falls == 1 && rises == 2, "R10 rebond clears and resets", falls, 1);
    else if (ok_exp) chk(falls == 0 && rises == 1, "R10 bonded stays", falls, 0);
  endtask

  initial begin
    trial(0, 0, 0, 20, -1, 0, 0, 8'hBC);
    for (int s = -(WIN + 1); s <= WIN + 1; s++)
      trial(s, 2, -1, 22, -1, 0, (s & 1), 8'hBC);
    trial(3, -4, 5, 20, -1, 0, 1, 8'hBC);
    trial(-5, 5, 0, 24, -1, 0, 0, 8'hBC);
    trial(1, 2, 6, 20, -1, 0, 0, 8'hBC);       // R9 late beyond window
    trial(0, 0, 0, 20, -1, 1, 0, 8'hBC);       // R5 master lacks char
    trial(1, -1, 2, 20, -1, 2, 1, 8'hBC);      // R4 flag low
    trial(2, -3, 1, 15, 45, 0, 0, 8'hBC);      // R10 second bonding event
    trial(0, 1, -1, 1000, -1, 0, 2, 8'hBC);    // R2 full-buffer stall, R3 hold
    trial(1, 1, -2, 20, -1, 0, 1, 8'hF7);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule